// File: doc/BRIEF.md
# Effective-Width Gated Accumulate Adder

This block is the addition stage of a multiply-accumulate datapath. It adds a signed 32-bit product P to a signed 32-bit addend Z and returns the full 33-bit two's-complement sum one clock later. The operation width changes from one operation to the next. Two inputs give the signed widths of the multiplier operands. From them the block estimates how many bits the product can occupy. It also measures how many bits Z needs. The larger of the two, plus one carry bit, becomes the effective length of this operation.

Only result register bits below the effective length are loaded. Bits at or above it keep the value of the previous operation, so they do not toggle. At the output, the bit just below the effective length carries the sign and is copied into every higher position. This restores the correct full-width value. The effective length is also driven out, so that a later stage can use the same reduced word length.

A producer drives `in_valid` with one operation per cycle. Operations may come back-to-back. While `in_valid` is low, the outputs hold their values.

Top module: `gated_acc_adder`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `sum_out` equals the 33-bit two's-complement sum of `prod` and `addend`, both sign-extended.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, including on every cycle of a back-to-back stream.
- R3: The addend width is the smallest n from 1 to 32 such that `addend` fits in n signed bits, so 0 and -1 have width 1. When this width exceeds the product estimate, `eff_len` is this width plus one.
- R4: The product estimate is `rng_a + rng_b`, capped at 32. When it is at least the addend width, `eff_len` is the estimate plus one.
- R5: `eff_len` equals the larger of the product estimate and the addend width, plus one, capped at 33. It is registered together with `sum_out`.
- R6: While `in_valid` is low, `sum_out` and `eff_len` keep their values. During an operation, result register bits at or above the effective length are not rewritten.
- R7: Every `sum_out` bit at position `eff_len` or above equals bit `eff_len-1`.
- R8: After a synchronous active-low reset, `out_valid` is 0, `sum_out` is 0 and `eff_len` is 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| prod | input | 32 | Signed product P |
| rng_a | input | 5 | Signed bit width of the first multiplier operand |
| rng_b | input | 5 | Signed bit width of the second multiplier operand |
| addend | input | 32 | Signed addend Z |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| sum_out | output | 33 | Sign-extended sum P+Z |
| eff_len | output | 6 | Effective word length used for this result |

## Verification
Operands are generated at many widths: narrow operands with a wide addend, wide operands with a narrow addend, zeros, -1, and the extreme values that produce a 33-bit carry or borrow. These patterns show whether the effective length comes from the addend side or the product side, and whether the carry bit was allowed for. A register bit that was frozen in one operation must come back to the right value through sign extension in the next. Random idle gaps between operations distinguish correct holding from stray updates. Long back-to-back runs confirm that a result appears every cycle.

// File: rtl/ewadd_pkg.sv
// Package: shared helpers for the effective-width accumulate adder.
// Assumes: integer arguments are small, non-negative widths.
package ewadd_pkg;
    // Larger of two widths.
    function automatic int umax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Width clamped to an upper limit.
    function automatic int ucap(input int a, input int lim);
        return (a > lim) ? lim : a;
    endfunction
endpackage

// File: rtl/ewadd_zrange.sv
// Module: measures the signed width of the addend.
// Output is the smallest n (1..W) such that z fits in n signed bits.
// Assumes: ZRW can hold the value W.
module ewadd_zrange #(
    parameter int W   = 32,
    parameter int ZRW = $clog2(W + 1)
) (
    input  logic [W-1:0]   z,
    output logic [ZRW-1:0] zr
);
    // Find the highest bit that differs from the sign bit.
    always_comb begin
        int n;
        n = 1;
        for (int i = 0; i < W - 1; i++) begin
            if (z[i] != z[W-1]) n = i + 2;
        end
        zr = ZRW'(n);
    end
endmodule

// File: rtl/ewadd_lensel.sv
// Module: picks the effective length and builds the per-bit load mask.
// The product width is estimated as the sum of the operand widths, capped at PW.
// One carry bit is added to the larger width, and the result is capped at OW.
// Assumes: the operand widths given are truthful for the product.
module ewadd_lensel
    import ewadd_pkg::*;
#(
    parameter int PW  = 32,
    parameter int RW  = 5,
    parameter int ZRW = 6,
    parameter int OW  = PW + 1,
    parameter int LW  = $clog2(OW + 1)
) (
    input  logic [RW-1:0]  rng_a,
    input  logic [RW-1:0]  rng_b,
    input  logic [ZRW-1:0] zr,
    output logic [LW-1:0]  len,
    output logic [OW-1:0]  mask
);
    // Estimate the product width, take the larger width, add the carry bit.
    always_comb begin
        int est;
        int l;
        est  = ucap(int'(rng_a) + int'(rng_b), PW);
        l    = ucap(umax(est, int'(zr)) + 1, OW);
        len  = LW'(l);
        for (int i = 0; i < OW; i++) mask[i] = (i < l);
    end
endmodule

// File: rtl/ewadd_holdreg.sv
// Module: result register with a load enable on each bit, plus the length register.
// A bit loads only when load is high and its mask bit is set; otherwise it holds.
// Assumes: mask is a contiguous run of ones starting at bit 0.
module ewadd_holdreg #(
    parameter int OW = 33,
    parameter int LW = $clog2(OW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [OW-1:0] d,
    input  logic [OW-1:0] mask,
    input  logic [LW-1:0] len_in,
    output logic [OW-1:0] q,
    output logic [LW-1:0] len_q
);
    logic [OW-1:0] en;
    assign en = load ? mask : '0;

    for (genvar i = 0; i < OW; i++) begin : g_bit
        // Load this bit when it is enabled, otherwise hold it.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= 1'b0;
            else if (en[i]) q[i] <= d[i];
        end
    end

    // Capture the effective length together with the result.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_q <= LW'(OW);
        else if (load) len_q <= len_in;
    end

    // R6
    frozen_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (((q ^ $past(q)) & ~$past(en)) == '0));

    // R5
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((mask & (mask + 1'b1)) == '0) && mask[0]);
endmodule

// File: rtl/ewadd_signext.sv
// Module: rebuilds the full-width value by copying bit len-1 into every higher bit.
// Assumes: len is between 1 and OW.
module ewadd_signext #(
    parameter int OW = 33,
    parameter int LW = $clog2(OW + 1)
) (
    input  logic [OW-1:0] q,
    input  logic [LW-1:0] len,
    output logic [OW-1:0] y
);
    // Replace each non-effective bit with the effective sign bit.
    always_comb begin
        int sb;
        sb = (len == '0) ? 0 : int'(len) - 1;
        for (int i = 0; i < OW; i++) y[i] = (i < int'(len)) ? q[i] : q[sb];
    end
endmodule

// File: rtl/gated_acc_adder.sv
// Module: top of the effective-width gated accumulate adder.
// Computes P+Z at 33 bits with a one-cycle latency and accepts one operation per cycle.
// Bits above the effective length are frozen and restored by sign extension.
// Assumes: rng_a and rng_b are upper bounds on the signed widths of the multiplier operands.
module gated_acc_adder #(
    parameter int PW  = 32,
    parameter int OPW = 16,
    localparam int OW  = PW + 1,
    localparam int RW  = $clog2(OPW + 1),
    localparam int ZRW = $clog2(PW + 1),
    localparam int LW  = $clog2(OW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] prod,
    input  logic [RW-1:0] rng_a,
    input  logic [RW-1:0] rng_b,
    input  logic [PW-1:0] addend,
    output logic          out_valid,
    output logic [OW-1:0] sum_out,
    output logic [LW-1:0] eff_len
);
    logic [ZRW-1:0] zr;
    logic [LW-1:0]  len_new;
    logic [OW-1:0]  mask;
    logic [OW-1:0]  sum_new;
    logic [OW-1:0]  q;

    ewadd_zrange #(.W(PW), .ZRW(ZRW)) u_zrange (
        .z  (addend),
        .zr (zr)
    );

    ewadd_lensel #(.PW(PW), .RW(RW), .ZRW(ZRW), .OW(OW), .LW(LW)) u_lensel (
        .rng_a (rng_a),
        .rng_b (rng_b),
        .zr    (zr),
        .len   (len_new),
        .mask  (mask)
    );

    // Sign-extended addition; only the masked bits are stored.
    assign sum_new = {prod[PW-1], prod} + {addend[PW-1], addend};

    ewadd_holdreg #(.OW(OW), .LW(LW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_valid),
        .d      (sum_new),
        .mask   (mask),
        .len_in (len_new),
        .q      (q),
        .len_q  (eff_len)
    );

    ewadd_signext #(.OW(OW), .LW(LW)) u_sext (
        .q   (q),
        .len (eff_len),
        .y   (sum_out)
    );

    // Delay the strobe to line up with the result.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // R1
    sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sum_out == $past({prod[PW-1], prod} + {addend[PW-1], addend})));

    // R2
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (eff_len >= LW'(2)) && (eff_len <= LW'(OW)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out) && $stable(eff_len));
endmodule

// File: tb/gated_acc_adder_tb.sv
module gated_acc_adder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] prod = '0;
    logic [31:0] addend = '0;
    logic [4:0]  rng_a = '0;
    logic [4:0]  rng_b = '0;
    wire         out_valid;
    wire  [32:0] sum_out;
    wire  [5:0]  eff_len;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference state
    bit          pv = 0;
    logic [32:0] esum = '0;
    int          elen = 33;
    int          epr = 0;
    int          ezr = 0;

    gated_acc_adder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prod(prod),
        .rng_a(rng_a), .rng_b(rng_b), .addend(addend),
        .out_valid(out_valid), .sum_out(sum_out), .eff_len(eff_len)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sw(input longint v, input int w);
        for (int n = 1; n <= w; n++) begin
            if (v >= -(longint'(1) <<< (n - 1)) && v < (longint'(1) <<< (n - 1))) return n;
        end
        return w;
    endfunction

    task automatic compare();
        if (pv) begin
            bit ok;
            int l;
            chk(out_valid == 1'b1, "R2", out_valid, 1);
            chk(sum_out == esum, "R1", sum_out, esum);
            chk(int'(eff_len) == elen, "R5", eff_len, elen);
            if (ezr > epr) chk(int'(eff_len) == ezr + 1, "R3", eff_len, ezr + 1);
            else           chk(int'(eff_len) == epr + 1, "R4", eff_len, epr + 1);
            ok = 1;
            l = (eff_len == 0) ? 1 : int'(eff_len);
            for (int i = l; i < 33; i++) if (sum_out[i] != sum_out[l-1]) ok = 0;
            chk(ok, "R7", sum_out, esum);
        end else begin
            chk(out_valid == 1'b0, "R2", out_valid, 0);
            chk(sum_out == esum, "R6", sum_out, esum);
            chk(int'(eff_len) == elen, "R6", eff_len, elen);
        end
    endtask

    task automatic op(input bit v, input logic signed [15:0] x, input logic signed [15:0] y,
                      input logic signed [31:0] z);
        int rx, ry;
        longint p;
        @(negedge clk);
        compare();
        p  = longint'(x) * longint'(y);
        rx = sw(longint'(x), 16);
        ry = sw(longint'(y), 16);
        in_valid = v;
        prod     = 32'(p);
        addend   = z;
        rng_a    = 5'(rx);
        rng_b    = 5'(ry);
        pv = v;
        if (v) begin
            epr  = (rx + ry > 32) ? 32 : rx + ry;
            ezr  = sw(longint'(z), 32);
            elen = ((epr > ezr) ? epr : ezr) + 1;
            if (elen > 33) elen = 33;
            esum = 33'(p + longint'(z));
        end
    endtask

    task automatic rnd_op();
        logic signed [15:0] x, y;
        logic signed [31:0] z;
        bit v;
        x = 16'($urandom);
        y = 16'($urandom);
        z = 32'($urandom);
        x = x >>> ($urandom % 16);
        y = y >>> ($urandom % 16);
        z = z >>> ($urandom % 32);
        v = ($urandom % 4) != 0;
        op(v, x, y, z);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(out_valid == 1'b0, "R8", out_valid, 0);
        chk(sum_out == 33'd0, "R8", sum_out, 0);
        chk(eff_len == 6'd33, "R8", eff_len, 33);
        rst_n = 1'b1;
        op(1, 16'sd0, 16'sd0, 32'sd0);                 // R3 zero addend, width 1
        op(1, 16'sd0, 16'sd5, -32'sd1);                // R3 minus one, width 1
        op(1, 16'sd3, 16'sd2, 32'sh4000_0000);         // R3 wide addend, narrow product
        op(1, -16'sd32768, -16'sd32768, 32'sh7FFF_FFFF); // R1 carry into bit 32
        op(1, 16'sd32767, -16'sd32768, 32'sh8000_0000);  // R1 borrow into bit 32
        op(1, 16'sd1, 16'sd1, 32'sd1);                 // R4 narrow product, frozen high bits
        op(0, 16'sd0, 16'sd0, 32'sd0);                 // R6 idle hold
        op(0, 16'sd7, 16'sd7, 32'sd9);                 // R6 idle hold, inputs change
        op(1, -16'sd1, 16'sd1, 32'sd0);                // R7 negative after positive
        op(1, -16'sd300, 16'sd200, 32'sd12);           // R4 product dominates
        for (int k = 0; k < 3000; k++) rnd_op();
        op(0, 16'sd0, 16'sd0, 32'sd0);
        op(0, 16'sd0, 16'sd0, 32'sd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule